// File: doc/BRIEF.md
# Prescaled Fixed-Interval Pulse Generator

The block makes periodic output pulses from the tick strobe of a nanosecond timer core, for example a once-per-second marker. Each timer tick carries a nominal step of `tick_ns_i` nanoseconds. A shared prescaler divides the tick stream into a slower output clock, and one period of that output clock sets how long every output pulse lasts.

Each of the `NCH` channels has a period register that holds the wanted interval in nanoseconds minus one tick period. A channel counts this value down by the tick step on every tick. When less than one step is left, the channel fires, raises its pulse and reloads from the period register, so consecutive intervals line up with no gap. Some examples with a 10 ns tick: a register value of 999,999,990 gives one pulse per second, and 99,990 gives one pulse every 100 µs. A prescaler of 100 gives 1 µs pulses.

Top module: `fiper_gen`

## Requirements
- R1: After reset every pulse output and the output clock strobe are low, and every period register is zero.
- R2: `oclk_o` is high for the one cycle that follows every P-th tick counted from reset, where P is `prsc_i`. A `prsc_i` of zero acts as one. It is low in any cycle that does not follow a tick.
- R3: A write (`per_we_i[c]` high at a clock edge) loads `per_wdata_i` into channel c's period register and restarts its count. The channel's pulse is low after that edge, and a tick in the same cycle is ignored by that channel.
- R4: With register value V and step T = `tick_ns_i` (nonzero), a channel fires on tick number floor(V/T)+1 after a write, and then on every floor(V/T)+1 ticks after that without drift. Loading the interval minus T therefore gives interval/T ticks.
- R5: A pulse rises at the edge that samples the firing tick and falls at the edge that samples the P-th tick after it, so it spans P ticks. If P is not smaller than the interval in ticks, the output stays high from the first firing onward.
- R6: A channel whose period register is zero never raises its pulse.
- R7: Channels are independent. A write to one channel, or that channel's value, does not change another channel's pulse sequence.
- R8: In a cycle with no tick and no write to a channel, that channel's pulse output keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer tick strobe, one cycle per tick |
| tick_ns_i | input | TNS_W | Nominal tick period in ns, nonzero |
| prsc_i | input | PRSC_W | Prescaler ratio, ticks per output clock |
| per_we_i | input | NCH | Per-channel period register write strobe |
| per_wdata_i | input | PER_W | Period register write data (interval minus one tick, ns) |
| oclk_o | output | 1 | Prescaled output clock strobe |
| pulse_o | output | NCH | Per-channel pulse outputs |

## Verification
The bench sweeps interval lengths from one tick upward, prescaler ratios below, equal to and above the interval, period values that are not a whole number of steps, and two tick spacings. Every output is compared with an arithmetic prediction after each tick and in the idle cycles between ticks. An off-by-one in the exhaust compare would shift every firing by one tick. A reload that wrongly subtracts the step would drift across intervals. A width counter loaded without the minus one would stretch pulses by one tick. Other targeted cases cover the following: a write that coincides with a tick (a design that counts that tick fires one tick early), a rewrite in the middle of a pulse (the pulse must drop at once), a zero period (it must never pulse), and a prescaler of zero (it must act as one).

// File: rtl/fiper_pkg.sv
package fiper_pkg;
  localparam int unsigned NCH_DEF    = 2;
  localparam int unsigned PER_W_DEF  = 32;
  localparam int unsigned TNS_W_DEF  = 8;
  localparam int unsigned PRSC_W_DEF = 16;

  typedef enum logic {
    PS_LOW  = 1'b0,
    PS_HIGH = 1'b1
  } pulse_st_e;
endpackage

// File: rtl/fiper_prescaler.sv
module fiper_prescaler #(
  parameter int unsigned PRSC_W = fiper_pkg::PRSC_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [PRSC_W-1:0] prsc_i,
  output logic [PRSC_W-1:0] prsc_eff_o,
  output logic              oclk_o
);
  logic [PRSC_W-1:0] pcnt_q;
  logic              oclk_q;

  // zero ratio behaves as divide-by-one
  assign prsc_eff_o = (prsc_i == '0) ? PRSC_W'(1) : prsc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      oclk_q <= 1'b0;
    end else if (tick_i) begin
      // >= keeps the count bounded when the ratio is lowered on the fly
      if (pcnt_q >= prsc_eff_o - PRSC_W'(1)) begin
        pcnt_q <= '0;
        oclk_q <= 1'b1;
      end else begin
        pcnt_q <= pcnt_q + PRSC_W'(1);
        oclk_q <= 1'b0;
      end
    end else begin
      oclk_q <= 1'b0;
    end
  end

  assign oclk_o = oclk_q;
endmodule

// File: rtl/fiper_channel.sv
module fiper_channel #(
  parameter int unsigned PER_W  = fiper_pkg::PER_W_DEF,
  parameter int unsigned TNS_W  = fiper_pkg::TNS_W_DEF,
  parameter int unsigned PRSC_W = fiper_pkg::PRSC_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [TNS_W-1:0]  tick_ns_i,
  input  logic [PRSC_W-1:0] width_i,
  input  logic              we_i,
  input  logic [PER_W-1:0]  wdata_i,
  output logic [PER_W-1:0]  per_o,
  output logic              pulse_o
);
  import fiper_pkg::*;

  logic [PER_W-1:0]  per_q;
  logic [PER_W-1:0]  cnt_q;
  logic [PRSC_W-1:0] wcnt_q;
  pulse_st_e         st_q;
  logic [PER_W-1:0]  step;
  logic              exhausted;
  logic              enabled;

  assign step      = PER_W'(tick_ns_i);
  assign exhausted = cnt_q < step;
  assign enabled   = per_q != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q  <= '0;
      cnt_q  <= '0;
      wcnt_q <= '0;
      st_q   <= PS_LOW;
    end else if (we_i) begin
      // write wins over a coinciding tick
      per_q  <= wdata_i;
      cnt_q  <= wdata_i;
      wcnt_q <= '0;
      st_q   <= PS_LOW;
    end else if (tick_i) begin
      if (!enabled) begin
        cnt_q <= '0;
        st_q  <= PS_LOW;
      end else if (exhausted) begin
        cnt_q  <= per_q;
        wcnt_q <= width_i - PRSC_W'(1);
        st_q   <= PS_HIGH;
      end else begin
        cnt_q <= cnt_q - step;
        if (st_q == PS_HIGH) begin
          if (wcnt_q == '0) st_q <= PS_LOW;
          else              wcnt_q <= wcnt_q - PRSC_W'(1);
        end
      end
    end
  end

  assign per_o   = per_q;
  assign pulse_o = (st_q == PS_HIGH);
endmodule

// File: rtl/fiper_gen.sv
module fiper_gen #(
  parameter int unsigned NCH    = fiper_pkg::NCH_DEF,
  parameter int unsigned PER_W  = fiper_pkg::PER_W_DEF,
  parameter int unsigned TNS_W  = fiper_pkg::TNS_W_DEF,
  parameter int unsigned PRSC_W = fiper_pkg::PRSC_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [TNS_W-1:0]  tick_ns_i,
  input  logic [PRSC_W-1:0] prsc_i,
  input  logic [NCH-1:0]    per_we_i,
  input  logic [PER_W-1:0]  per_wdata_i,
  output logic              oclk_o,
  output logic [NCH-1:0]    pulse_o
);
  localparam int unsigned PER_FLAT_W = NCH * PER_W;

  logic [PRSC_W-1:0]     prsc_eff;
  logic [PER_FLAT_W-1:0] per_flat;

  fiper_prescaler #(.PRSC_W(PRSC_W)) i_prescaler (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .prsc_i     (prsc_i),
    .prsc_eff_o (prsc_eff),
    .oclk_o     (oclk_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    fiper_channel #(
      .PER_W (PER_W),
      .TNS_W (TNS_W),
      .PRSC_W(PRSC_W)
    ) i_channel (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .tick_ns_i(tick_ns_i),
      .width_i  (prsc_eff),
      .we_i     (per_we_i[c]),
      .wdata_i  (per_wdata_i),
      .per_o    (per_flat[c*PER_W +: PER_W]),
      .pulse_o  (pulse_o[c])
    );
  end
endmodule

// File: rtl/fiper_gen_chk.sv
module fiper_gen_chk #(
  parameter int unsigned NCH   = 2,
  parameter int unsigned PER_W = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 tick_i,
  input logic [NCH-1:0]       per_we_i,
  input logic                 oclk_o,
  input logic [NCH-1:0]       pulse_o,
  input logic [NCH*PER_W-1:0] per_flat
);
  // R2: the strobe only follows a tick
  p_oclk_after_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !oclk_o);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R6: a zero period register never pulses
    p_zero_period_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (per_flat[c*PER_W +: PER_W] == '0) |-> !pulse_o[c]);

    // R3: a write drops the pulse
    p_write_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      per_we_i[c] |=> !pulse_o[c]);

    // R8: no tick and no write, no change
    p_hold_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && !per_we_i[c]) |=> $stable(pulse_o[c]));

    // R5: rises only on a tick edge
    p_rise_on_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pulse_o[c]) |-> $past(tick_i));
  end
endmodule

bind fiper_gen fiper_gen_chk #(.NCH(NCH), .PER_W(PER_W)) i_fiper_gen_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .per_we_i(per_we_i),
  .oclk_o  (oclk_o),
  .pulse_o (pulse_o),
  .per_flat(per_flat)
);

// File: tb/test_fiper_gen.sv
`timescale 1ns/1ps
module test_fiper_gen;
  localparam int NCH = 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [7:0]  tick_ns_i = 8'd10;
  logic [15:0] prsc_i = 16'd1;
  logic [1:0]  per_we_i = '0;
  logic [31:0] per_wdata_i = '0;
  logic        oclk_o;
  logic [1:0]  pulse_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int k0 = 0, k1 = 0;   // ticks since last write, per channel
  int n0 = 0, n1 = 0;   // interval in ticks, 0 = disabled
  int pw = 1;           // effective prescaler

  always #2.5 clk = ~clk;

  fiper_gen i_fiper_gen (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .tick_ns_i  (tick_ns_i),
    .prsc_i     (prsc_i),
    .per_we_i   (per_we_i),
    .per_wdata_i(per_wdata_i),
    .oclk_o     (oclk_o),
    .pulse_o    (pulse_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_pulse(input int k, input int n, input int p);
    if (n == 0) return 0;
    if (k < n) return 0;
    return (((k - n) % n) < p) ? 1 : 0;
  endfunction

  function automatic int ticks_for(input int v, input int t);
    return (v == 0) ? 0 : v / t + 1;
  endfunction

  task automatic wr(input logic [1:0] mask, input int v, input bit with_tick);
    @(negedge clk);
    per_we_i    = mask;
    per_wdata_i = v;
    tick_i      = with_tick;
    @(negedge clk);
    per_we_i = '0;
    tick_i   = 1'b0;
    if (mask[0]) begin k0 = 0; n0 = ticks_for(v, int'(tick_ns_i)); end
    if (mask[1]) begin k1 = 0; n1 = ticks_for(v, int'(tick_ns_i)); end
    // R3: pulse low right after the write edge
    for (int c = 0; c < 2; c++)
      if (mask[c]) check(pulse_o[c] == 1'b0, "R3 write clears", int'(pulse_o[c]), 0);
  endtask

  task automatic cmp_both(input string tag);
    int e0, e1;
    e0 = exp_pulse(k0, n0, pw);
    e1 = exp_pulse(k1, n1, pw);
    check(int'(pulse_o[0]) == e0, {tag, " ch0"}, int'(pulse_o[0]), e0);
    check(int'(pulse_o[1]) == e1, {tag, " ch1"}, int'(pulse_o[1]), e1);
  endtask

  task automatic run(input int nticks, input int gap, input string tag);
    for (int i = 0; i < nticks; i++) begin
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      k0++; k1++;
      cmp_both(tag);
      for (int g = 1; g < gap; g++) begin
        @(negedge clk);
        cmp_both("R8 idle hold");
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(pulse_o == 2'b00, "R1 pulses low", int'(pulse_o), 0);
    check(oclk_o == 1'b0, "R1 oclk low", int'(oclk_o), 0);

    // R2 prescaler strobe, ratio 3, counted from reset
    prsc_i = 16'd3;
    for (int k = 1; k <= 9; k++) begin
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      check(int'(oclk_o) == ((k % 3 == 0) ? 1 : 0), "R2 oclk ratio 3", int'(oclk_o), (k % 3 == 0) ? 1 : 0);
      @(negedge clk);
      check(oclk_o == 1'b0, "R2 oclk idle low", int'(oclk_o), 0);
    end
    // R1 disabled channels never pulsed after reset
    check(pulse_o == 2'b00, "R1 channels disabled", int'(pulse_o), 0);
    // R2 zero ratio acts as one
    prsc_i = 16'd0;
    for (int k = 1; k <= 3; k++) begin
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      check(oclk_o == 1'b1, "R2 zero ratio", int'(oclk_o), 1);
    end

    // R4/R5/R7 sweep: step, interval, width, tick spacing
    for (int t = 0; t < 2; t++) begin
      tick_ns_i = (t == 0) ? 8'd10 : 8'd7;
      for (int a = 1; a <= 5; a++) begin
        for (int p = 0; p <= 4; p++) begin
          for (int gap = 1; gap <= 2; gap++) begin
            int v0, v1, tn;
            tn = int'(tick_ns_i);
            v0 = (a - 1) * tn + (a % tn);     // remainder exercises floor
            v1 = (a + 1) * tn;
            prsc_i = 16'(p);
            pw = (p == 0) ? 1 : p;
            wr(2'b10, v1, 1'b0);
            wr(2'b01, v0, 1'b0);
            run(3 * (a + 2) + pw, gap, "R4 R5 R7 sweep");
          end
        end
      end
    end

    // R3 coinciding tick is ignored by the written channels
    tick_ns_i = 8'd10;
    prsc_i = 16'd1;
    pw = 1;
    wr(2'b11, 20, 1'b1);
    run(2, 1, "R3 tick with write");
    check(pulse_o == 2'b00, "R3 no early fire", int'(pulse_o), 0);
    run(4, 1, "R3 tick with write");

    // R3/R7 restart mid-pulse on ch0 only, ch1 keeps its sequence
    prsc_i = 16'd2;
    pw = 2;
    wr(2'b10, 30, 1'b0);
    wr(2'b01, 20, 1'b0);
    run(3, 1, "R5 before restart");
    check(pulse_o[0] == 1'b1, "R5 ch0 high", int'(pulse_o[0]), 1);
    wr(2'b01, 20, 1'b0);
    cmp_both("R7 other channel unaffected");
    run(10, 2, "R3 R7 after restart");

    // R6 zero period stays low while the other channel runs
    wr(2'b10, 0, 1'b0);
    wr(2'b01, 10, 1'b0);
    run(12, 1, "R6 zero period");
    check(pulse_o[1] == 1'b0, "R6 ch1 low", int'(pulse_o[1]), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule